// File: doc/BRIEF.md
# Autonomous Burst-Mode ADC Sequencer

This block is a digital controller that sits beside a successive-approximation converter core. It waits for a start event from one of five selectable sources. When one arrives, it powers the converter up, waits out a programmable power-up interval, and then runs a programmed number of conversions back to back. Each conversion is preceded by a programmable tracking interval. Every result is added into a 16-bit saturating accumulator. At the end of the burst the converter is powered down again, with no processor action.

Two results are presented when the burst ends: the raw sum and an averaged value. The average is the sum shifted right by the base-2 logarithm of the sample count. A one-cycle completion pulse marks the cycle in which both are valid. Results can be taken as 10-bit or 12-bit values. The resolution and the sample count are captured when the burst starts.

Top module: `burst_adc_seq`

## Requirements
- R1: `trig_sel` codes 0, 1, 2, 3 and 4 select, in that order, `sw_start`, `ext_start`, `tmr0_ovf`, `tmr2_ovf` and `tmr3_ovf`. Start inputs are active-high pulses. A high level on the selected source in an idle cycle begins a burst, and `busy` goes high in the next cycle.
- R2: `trig_sel` codes 5, 6 and 7 select no source. With any of them, no start input begins a burst: `busy` and `conv_en` stay low.
- R3: Start pulses on sources that are not selected are ignored. So is any start pulse that arrives while a burst is running: exactly one burst, with the programmed number of conversions, takes place.
- R4: `conv_en` rises in the cycle after the start is accepted. The first `conv_start` pulse comes after `pwrup_cyc + track_cyc + 2` cycles in which `conv_en` is high.
- R5: Each conversion begins with a one-cycle `conv_start` pulse while `conv_en` is high. The sequencer then waits, for as long as it takes, until `conv_done` is high, and takes `conv_data` in that cycle.
- R6: `rpt_code` values 0 through 5 give 1, 4, 8, 16, 32 and 64 conversions per burst. Values 6 and 7 give 64.
- R7: With `mode12` = 0, only `conv_data[9:0]` is summed. With `mode12` = 1, all of `conv_data[11:0]` is summed.
- R8: The sum is cleared when a burst starts. It holds the running total of the samples and saturates at 0xFFFF.
- R9: `avg_out` equals `acc_sum` shifted right by 0, 2, 3, 4, 5 or 6 bits, to match the sample count of the burst.
- R10: `done` is high for exactly one cycle, the first in which the final sum is on `acc_sum`. `conv_en` is low in that cycle and stays low while idle. `busy` stays high from the cycle after the start through the `done` cycle, and is low after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_sel | input | 3 | Start source select |
| mode12 | input | 1 | 1 = 12-bit results, 0 = 10-bit results |
| rpt_code | input | 3 | Conversions-per-burst code |
| pwrup_cyc | input | 8 | Power-up wait setting |
| track_cyc | input | 6 | Tracking wait setting |
| sw_start | input | 1 | Software start pulse |
| ext_start | input | 1 | External convert-start pulse |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr2_ovf | input | 1 | Timer 2 overflow pulse |
| tmr3_ovf | input | 1 | Timer 3 overflow pulse |
| conv_done | input | 1 | Converter result ready |
| conv_data | input | 12 | Converter result |
| conv_en | output | 1 | Converter power enable |
| conv_start | output | 1 | Converter start pulse |
| busy | output | 1 | Burst in progress |
| done | output | 1 | Burst complete pulse |
| acc_sum | output | 16 | Accumulated sum |
| avg_out | output | 16 | Averaged result |

## Verification
The assertions check, on every cycle, the local rules of the handshake and the timing. `done` lasts one cycle and never coincides with `conv_en`. `busy` cannot drop before `done`. A burst never starts without a selected hit. `conv_start` only occurs while the converter is powered. The sum never decreases within a burst. Only the bench scenarios can show the end-to-end results. These are the mapping of start sources and their codes, the exact power-up and tracking delays, the number of conversions for each count code, 10-bit masking, saturation, the averaging shift, and the dropping of repeated start pulses. The bench's converter model supplies known data patterns for these checks.

// File: rtl/burst_adc_pkg.sv
package burst_adc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POWERUP,
        ST_TRACK,
        ST_CONVERT,
        ST_ACCUM,
        ST_SHUTDOWN
    } burst_state_e;

    // Right-shift amount (log2 of sample count) for a count code.
    function automatic logic [2:0] rpt_shift(input logic [2:0] code);
        case (code)
            3'd0:    return 3'd0;
            3'd1:    return 3'd2;
            3'd2:    return 3'd3;
            3'd3:    return 3'd4;
            3'd4:    return 3'd5;
            default: return 3'd6;
        endcase
    endfunction

endpackage

// File: rtl/burst_trig_sel.sv
module burst_trig_sel #(
    parameter int NUM_SRC = 5,
    parameter int SEL_W   = 3
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_SRC-1:0] src,
    output logic               hit
);
    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel == SEL_W'(i)) hit = src[i];
        end
    end
endmodule

// File: rtl/burst_accum.sv
module burst_accum #(
    parameter int RES_W    = 12,
    parameter int NARROW_W = 10,
    parameter int ACC_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add,
    input  logic             wide,
    input  logic [RES_W-1:0] sample,
    output logic [ACC_W-1:0] sum
);
    localparam logic [RES_W-1:0] NARROW_MASK = RES_W'((1 << NARROW_W) - 1);

    logic [ACC_W-1:0] sum_d, sum_q;
    logic [RES_W-1:0] masked;
    logic [ACC_W:0]   wide_sum;

    always_comb begin
        masked   = wide ? sample : (sample & NARROW_MASK);
        wide_sum = {1'b0, sum_q} + (ACC_W+1)'(masked);
        sum_d    = sum_q;
        if (clr)
            sum_d = '0;
        else if (add)
            sum_d = wide_sum[ACC_W] ? {ACC_W{1'b1}} : wide_sum[ACC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    assign sum = sum_q;

    // R8: without a clear, the running sum never goes down (saturation, no wrap)
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (sum_q >= $past(sum_q)));
endmodule

// File: rtl/burst_adc_seq.sv
module burst_adc_seq
    import burst_adc_pkg::*;
#(
    parameter int RES_W  = 12,
    parameter int ACC_W  = 16,
    parameter int PU_W   = 8,
    parameter int TK_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       trig_sel,
    input  logic             mode12,
    input  logic [2:0]       rpt_code,
    input  logic [PU_W-1:0]  pwrup_cyc,
    input  logic [TK_W-1:0]  track_cyc,
    input  logic             sw_start,
    input  logic             ext_start,
    input  logic             tmr0_ovf,
    input  logic             tmr2_ovf,
    input  logic             tmr3_ovf,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    output logic             conv_en,
    output logic             conv_start,
    output logic             busy,
    output logic             done,
    output logic [ACC_W-1:0] acc_sum,
    output logic [ACC_W-1:0] avg_out
);
    localparam int NUM_SRC = 5;
    localparam int CNT_W   = (PU_W > TK_W) ? PU_W : TK_W;
    localparam int LEFT_W  = 7;

    typedef struct packed {
        burst_state_e      st;
        logic [CNT_W-1:0]  dly;
        logic [LEFT_W-1:0] left;
        logic [2:0]        shift;
        logic              wide;
        logic              cstart;
        logic [RES_W-1:0]  sample;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      trig_hit;
    logic      acc_clr, acc_add;

    burst_trig_sel #(.NUM_SRC(NUM_SRC), .SEL_W(3)) i_trig (
        .sel (trig_sel),
        .src ({tmr3_ovf, tmr2_ovf, tmr0_ovf, ext_start, sw_start}),
        .hit (trig_hit)
    );

    always_comb begin
        r_d        = r_q;
        r_d.cstart = 1'b0;
        acc_clr    = 1'b0;
        acc_add    = 1'b0;
        case (r_q.st)
            ST_IDLE: if (trig_hit) begin
                r_d.st    = ST_POWERUP;
                r_d.dly   = CNT_W'(pwrup_cyc);
                r_d.shift = rpt_shift(rpt_code);
                r_d.left  = LEFT_W'((1 << rpt_shift(rpt_code)) - 1);
                r_d.wide  = mode12;
                acc_clr   = 1'b1;
            end
            ST_POWERUP, ST_TRACK: begin
                if (r_q.dly == '0) begin
                    if (r_q.st == ST_POWERUP) begin
                        r_d.st  = ST_TRACK;
                        r_d.dly = CNT_W'(track_cyc);
                    end else begin
                        r_d.st     = ST_CONVERT;
                        r_d.cstart = 1'b1;
                    end
                end else begin
                    r_d.dly = r_q.dly - 1'b1;
                end
            end
            ST_CONVERT: if (conv_done) begin
                r_d.sample = conv_data;
                r_d.st     = ST_ACCUM;
            end
            ST_ACCUM: begin
                acc_add = 1'b1;
                if (r_q.left == '0) begin
                    r_d.st = ST_SHUTDOWN;
                end else begin
                    r_d.left = r_q.left - 1'b1;
                    r_d.st   = ST_TRACK;
                    r_d.dly  = CNT_W'(track_cyc);
                end
            end
            ST_SHUTDOWN: r_d.st = ST_IDLE;
            default:     r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, dly: '0, left: '0, shift: '0,
                     wide: 1'b0, cstart: 1'b0, sample: '0};
        end else begin
            r_q <= r_d;
        end
    end

    burst_accum #(.RES_W(RES_W), .NARROW_W(10), .ACC_W(ACC_W)) i_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (acc_clr),
        .add    (acc_add),
        .wide   (r_q.wide),
        .sample (r_q.sample),
        .sum    (acc_sum)
    );

    assign busy       = (r_q.st != ST_IDLE);
    assign done       = (r_q.st == ST_SHUTDOWN);
    assign conv_en    = busy && !done;
    assign conv_start = r_q.cstart;
    assign avg_out    = acc_sum >> r_q.shift;

    // R10: completion is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: converter is unpowered in the completion cycle
    a_r10_off_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !conv_en);
    // R10: busy cannot end before completion
    a_r10_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    // R5: conversions only start with the converter powered
    a_r5_start_powered: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> conv_en);
    // R2, R3: no burst begins without a selected start hit
    a_r3_no_spurious_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !trig_hit) |=> !busy);
endmodule

// File: tb/test_burst_adc_seq.sv
module test_burst_adc_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  trig_sel = 3'd0;
    logic        mode12 = 1'b1;
    logic [2:0]  rpt_code = 3'd0;
    logic [7:0]  pwrup_cyc = 8'd5;
    logic [5:0]  track_cyc = 6'd3;
    logic [4:0]  src = 5'd0;
    logic        conv_done = 1'b0;
    logic [11:0] conv_data = 12'd0;
    logic        conv_en, conv_start, busy, done;
    logic [15:0] acc_sum, avg_out;

    int checks = 0;
    int errors = 0;
    int lat = 0;
    int n_starts = 0;
    int k_idx = 0;
    int seed = 0;
    int stride = 0;

    always #2.5 clk = ~clk;

    burst_adc_seq i_burst_adc_seq (
        .clk(clk), .rst_n(rst_n), .trig_sel(trig_sel), .mode12(mode12),
        .rpt_code(rpt_code), .pwrup_cyc(pwrup_cyc), .track_cyc(track_cyc),
        .sw_start(src[0]), .ext_start(src[1]), .tmr0_ovf(src[2]),
        .tmr2_ovf(src[3]), .tmr3_ovf(src[4]),
        .conv_done(conv_done), .conv_data(conv_data),
        .conv_en(conv_en), .conv_start(conv_start), .busy(busy), .done(done),
        .acc_sum(acc_sum), .avg_out(avg_out)
    );

    function automatic int sample_val(int k);
        return (seed + k * stride) & 12'hFFF;
    endfunction

    // converter model: result three negedges after the start pulse
    always @(negedge clk) begin
        conv_done = 1'b0;
        if (lat > 0) begin
            lat = lat - 1;
            if (lat == 0) begin
                conv_done = 1'b1;
                conv_data = 12'(sample_val(k_idx));
                k_idx = k_idx + 1;
            end
        end
        if (conv_start) begin
            lat = 3;
            n_starts = n_starts + 1;
        end
    end

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic pulse(int idx);
        @(negedge clk);
        src = 5'd1 << idx;
        @(negedge clk);
        src = 5'd0;
    endtask

    task automatic wait_done(output int seen);
        seen = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done) begin seen = 1; break; end
        end
    endtask

    task automatic t_reset;
        check("R10 reset busy", busy, 0);
        check("R10 reset conv_en", conv_en, 0);
        check("R10 reset done", done, 0);
        check("R8 reset sum", acc_sum, 0);
    endtask

    task automatic t_burst(string req, int sel, int code, int wide,
                           int sd, int st, int n, int extra);
        int exp_sum, seen, sh, s;
        sh = (code == 0) ? 0 : (code >= 5 ? 6 : code + 1);
        seed = sd; stride = st; k_idx = 0; n_starts = 0;
        trig_sel = 3'(sel); rpt_code = 3'(code); mode12 = wide[0];
        exp_sum = 0;
        for (int k = 0; k < n; k++) begin
            s = sample_val(k);
            if (wide == 0) s = s & 10'h3FF;
            exp_sum = exp_sum + s;
            if (exp_sum > 65535) exp_sum = 65535;
        end
        pulse(sel);
        check({req, " busy after start"}, busy, 1);
        if (extra != 0) begin
            repeat (12) @(negedge clk);
            pulse(sel);
        end
        wait_done(seen);
        check({req, " done seen"}, seen, 1);
        check("R10 conv_en low at done", conv_en, 0);
        check({req, " sum"}, acc_sum, exp_sum);
        check("R9 average", avg_out, exp_sum >> sh);
        check({"R6 conversion count ", req}, n_starts, n);
        @(negedge clk);
        check("R10 done one cycle", done, 0);
        check("R10 busy low after done", busy, 0);
        repeat (3) @(negedge clk);
        check("R10 idle stays unpowered", conv_en, 0);
    endtask

    task automatic t_timing(int p, int t);
        int cnt;
        pwrup_cyc = 8'(p); track_cyc = 6'(t);
        trig_sel = 3'd0; rpt_code = 3'd0; n_starts = 0; k_idx = 0;
        pulse(0);
        cnt = 0;
        for (int i = 0; i < 1000; i++) begin
            if (conv_start) break;
            if (conv_en) cnt++;
            @(negedge clk);
        end
        check("R4 power-up plus track cycles", cnt, p + t + 2);
        check("R5 start pulse while powered", conv_en, 1);
        @(negedge clk);
        check("R5 start pulse one cycle", conv_start, 0);
        repeat (10) @(negedge clk);
        check("R5 waits for conv_done", busy, 0);
        pwrup_cyc = 8'd5; track_cyc = 6'd3;
    endtask

    task automatic t_ignored(string req, int sel, int idx);
        trig_sel = 3'(sel);
        pulse(idx);
        repeat (3) @(negedge clk);
        check({req, " busy stays low"}, busy, 0);
        check({req, " conv_en stays low"}, conv_en, 0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_burst("R1 sw start", 0, 0, 1, 1234, 0, 1, 0);
        t_burst("R7 narrow ext start", 1, 1, 0, 4000, 7, 4, 0);
        t_burst("R1 timer0", 2, 3, 1, 100, 37, 16, 0);
        t_burst("R1 timer2", 3, 2, 0, 3000, 55, 8, 0);
        t_burst("R8 timer3 wide", 4, 4, 1, 2000, 37, 32, 0);
        t_burst("R8 saturate", 0, 5, 1, 4000, 1, 64, 0);
        t_burst("R6 code 7", 1, 7, 0, 500, 3, 64, 0);
        t_burst("R3 start while busy", 0, 2, 1, 900, 11, 8, 1);
        t_timing(10, 2);
        t_timing(0, 0);
        for (int c = 5; c < 8; c++) begin
            for (int i = 0; i < 5; i++) t_ignored("R2 code 5-7", c, i);
        end
        t_ignored("R3 unselected source", 0, 1);
        t_ignored("R3 unselected source", 4, 2);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule